// File: doc/BRIEF.md
# Narrow-to-wide command packing router

This block sits on a 32-bit command channel that uses a valid/ready handshake. It decodes the address of each incoming flit against a table of address segments. Each segment is a base and a mask. One segment is marked as the local register window. The flit then goes one of three ways.

- A hit in the local window is served by a small internal register bank. The block answers it through a shared response path.
- A hit in any other segment is a remote access. The block captures the command fields, packs the 32-bit data into a 64-bit word and pushes it into an outgoing 64-bit command FIFO.
- A miss on every segment produces an error response.

For remote write bursts, a low-lane flit and the following high-lane flit are merged into a single 64-bit flit. The block never accepts input while it is offering a push to the outgoing FIFO. It also never accepts input while it is waiting for the response path to be granted.

Top module: `cmd_pack_router`

## Requirements
- R1: After reset the block is idle. `in_ready` is 1, and `out_push`, `rsp_req` and `rsp_push` are 0.
- R2: `in_ready` is 1 only while idle or while waiting for the second flit of a burst. It is 0 for every cycle in which `out_push` or `rsp_req` is 1.
- R3: Lane steering for a remote flit uses address bit 2.
  - When bit 2 is 1, the data lands in `out_wdata[63:32]` and the byte enables in `out_be[7:4]`, with the other lane zero.
  - When bit 2 is 0, the data lands in `out_wdata[31:0]` and the byte enables in `out_be[3:0]`, with the upper lane zero.
- R4: A remote flit with `in_last`=1 accepted while idle is offered as one push in the next cycle, with `out_last`=1.
- R5: A remote flit with `in_last`=0 and address bit 2 set is pushed on its own, with `out_last`=0.
- R6: Merging of a low-lane burst flit works as follows.
  - A remote flit with `in_last`=0 and address bit 2 clear is not pushed. The block waits with `in_ready`=1 for the next flit.
  - That next flit must target the previous address plus 4.
  - Its data and byte enables are ORed into the upper lane, and its `in_last` becomes `out_last`.
  - The merged word is then pushed.
- R7: Holding an offered push works as follows.
  - A push stays offered until `out_space` is 1, and the block returns to idle after that cycle.
  - While waiting, the offered address, command and identifier fields come from values captured at accept time. They do not change when the inputs change.
- R8: A local access uses register index `in_addr[8:2]`.
  - A write with `in_be`=4'hF and `in_last`=1 stores `in_wdata`.
  - A read returns the stored word in `rsp_data`.
  - In both cases `rsp_error` is 0.
- R9: A local access returns `rsp_error`=1 and `rsp_data`=0, and changes no register, in any of these cases:
  - the index is at least `LOC_REGS`;
  - `in_be` is not 4'hF;
  - `in_last` is 0.
- R10: A flit that hits no segment sets `rsp_error`=1 and `rsp_data`=0. A response is requested only when that flit has `in_last`=1. Earlier flits of the packet are accepted silently.
- R11: A requested response waits with `rsp_req`=1 until `rsp_grant` is 1. `rsp_push` equals `rsp_grant` while the response is requested. The block then returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Incoming flit valid |
| in_ready | output | 1 | Incoming flit accepted when high with in_valid |
| in_addr | input | AW | Byte address of the flit |
| in_write | input | 1 | 1 for write, 0 for read |
| in_wdata | input | 32 | Write data |
| in_be | input | 4 | Byte enables |
| in_last | input | 1 | Last flit of the packet |
| in_srcid | input | SW | Source identifier |
| in_trdid | input | TW | Thread identifier |
| in_pktid | input | PW | Packet identifier |
| in_plen | input | LW | Packet length attribute |
| out_push | output | 1 | Push request to the 64-bit command FIFO |
| out_space | input | 1 | Outgoing FIFO can take a word this cycle |
| out_addr | output | AW | Captured address |
| out_write | output | 1 | Captured command type |
| out_wdata | output | 64 | Packed write data |
| out_be | output | 8 | Packed byte enables |
| out_last | output | 1 | Last flit of the packed packet |
| out_srcid | output | SW | Captured source identifier |
| out_trdid | output | TW | Captured thread identifier |
| out_pktid | output | PW | Captured packet identifier |
| out_plen | output | LW | Captured packet length |
| rsp_req | output | 1 | Request for the shared response path |
| rsp_grant | input | 1 | Response path granted to this block |
| rsp_push | output | 1 | Response written this cycle |
| rsp_data | output | 32 | Response data |
| rsp_error | output | 1 | Response error flag |

## Verification
The bench builds the block with its default parameters. These are a three-entry segment table, a 512-byte local window at 0x1000 holding four registers, and two remote segments at 0x1000_0000 and 0x2000_0000. This leaves 0x3000_0000 unmapped for the error path. Because the window decodes 128 indices but only four exist, indices such as 9 reach the unknown-register error without leaving the window. Holding `out_space` and `rsp_grant` low for several cycles makes the captured-field hold and the grant wait visible at the ports.

// File: rtl/cmd_pack_router.sv
module cmd_pack_router #(
  parameter int AW       = 32,
  parameter int SW       = 8,
  parameter int TW       = 4,
  parameter int PW       = 4,
  parameter int LW       = 8,
  parameter int NSEG     = 3,
  parameter logic [NSEG*AW-1:0] SEG_BASE = {32'h2000_0000, 32'h1000_0000, 32'h0000_1000},
  parameter logic [NSEG*AW-1:0] SEG_MASK = {32'hF000_0000, 32'hF000_0000, 32'hFFFF_FE00},
  parameter int LOC_SEG  = 0,
  parameter int LOC_REGS = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [AW-1:0] in_addr,
  input  logic          in_write,
  input  logic [31:0]   in_wdata,
  input  logic [3:0]    in_be,
  input  logic          in_last,
  input  logic [SW-1:0] in_srcid,
  input  logic [TW-1:0] in_trdid,
  input  logic [PW-1:0] in_pktid,
  input  logic [LW-1:0] in_plen,
  output logic          out_push,
  input  logic          out_space,
  output logic [AW-1:0] out_addr,
  output logic          out_write,
  output logic [63:0]   out_wdata,
  output logic [7:0]    out_be,
  output logic          out_last,
  output logic [SW-1:0] out_srcid,
  output logic [TW-1:0] out_trdid,
  output logic [PW-1:0] out_pktid,
  output logic [LW-1:0] out_plen,
  output logic          rsp_req,
  input  logic          rsp_grant,
  output logic          rsp_push,
  output logic [31:0]   rsp_data,
  output logic          rsp_error
);
  localparam int RW = (LOC_REGS > 1) ? $clog2(LOC_REGS) : 1;

  typedef enum logic [1:0] {S_IDLE, S_NEXT, S_PUT, S_RSP} st_t;
  st_t st;

  logic [31:0] regs [LOC_REGS];
  logic        seg_hit, seg_loc;

  always_comb begin
    seg_hit = 1'b0;
    seg_loc = 1'b0;
    for (int i = 0; i < NSEG; i++)
      if ((in_addr & SEG_MASK[i*AW +: AW]) == SEG_BASE[i*AW +: AW]) begin
        seg_hit = 1'b1;
        if (i == LOC_SEG) seg_loc = 1'b1;
      end
  end

  wire [6:0]    loc_idx = in_addr[8:2];
  wire [RW-1:0] loc_sel = in_addr[RW+1:2];
  wire          loc_ok  = in_last && (in_be == 4'hF) && (int'(loc_idx) < LOC_REGS);
  wire          hi_lane = in_addr[2];
  wire [63:0]   lane_data = hi_lane ? {in_wdata, 32'h0} : {32'h0, in_wdata};
  wire [7:0]    lane_be   = hi_lane ? {in_be, 4'h0} : {4'h0, in_be};

  assign in_ready = (st == S_IDLE) || (st == S_NEXT);
  assign out_push = (st == S_PUT);
  assign rsp_req  = (st == S_RSP);
  assign rsp_push = rsp_req && rsp_grant;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      out_addr  <= '0;
      out_write <= 1'b0;
      out_wdata <= '0;
      out_be    <= '0;
      out_last  <= 1'b0;
      out_srcid <= '0;
      out_trdid <= '0;
      out_pktid <= '0;
      out_plen  <= '0;
      rsp_data  <= '0;
      rsp_error <= 1'b0;
      for (int i = 0; i < LOC_REGS; i++) regs[i] <= '0;
    end else begin
      case (st)
        S_IDLE: if (in_valid) begin
          if (seg_hit && seg_loc) begin
            rsp_error <= !loc_ok;
            rsp_data  <= (loc_ok && !in_write) ? regs[loc_sel] : 32'h0;
            if (loc_ok && in_write) regs[loc_sel] <= in_wdata;
            st <= S_RSP;
          end else if (seg_hit) begin
            out_addr  <= in_addr;
            out_write <= in_write;
            out_srcid <= in_srcid;
            out_trdid <= in_trdid;
            out_pktid <= in_pktid;
            out_plen  <= in_plen;
            out_wdata <= lane_data;
            out_be    <= lane_be;
            out_last  <= in_last;
            st        <= (in_last || hi_lane) ? S_PUT : S_NEXT;
          end else begin
            rsp_data  <= 32'h0;
            rsp_error <= 1'b1;
            if (in_last) st <= S_RSP;
          end
        end
        S_NEXT: if (in_valid) begin
          out_wdata[63:32] <= out_wdata[63:32] | in_wdata;
          out_be[7:4]      <= out_be[7:4] | in_be;
          out_last         <= in_last;
          st               <= S_PUT;
        end
        S_PUT: if (out_space) st <= S_IDLE;
        S_RSP: if (rsp_grant) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_BUSY_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_push || rsp_req) |-> !in_ready);                                        // R2
  AST_NEXT_CONTIG: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_NEXT && in_valid) |-> (in_addr == out_addr + AW'(4)));              // R6
  AST_PUSH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_push && !out_space) |=> (out_push && $stable(out_wdata) && $stable(out_be) && $stable(out_addr))); // R7
  AST_PUSH_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_push && out_space) |=> !out_push);                                      // R7
  AST_RSP_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_req && !rsp_grant) |=> (rsp_req && $stable(rsp_data) && $stable(rsp_error))); // R11
  AST_NO_DUAL: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_push && rsp_req));                                                     // R2
  AST_MISS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && st == S_IDLE && !seg_hit) |=> (rsp_error && rsp_data == 32'h0)); // R10
endmodule

// File: tb/cmd_pack_router_tb.sv
module cmd_pack_router_tb_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        in_valid = 0, in_write = 0, in_last = 0;
  logic [31:0] in_addr = 0, in_wdata = 0;
  logic [3:0]  in_be = 0;
  logic [7:0]  in_srcid = 0, in_plen = 0;
  logic [3:0]  in_trdid = 0, in_pktid = 0;
  logic        out_space = 1, rsp_grant = 1;
  logic        in_ready, out_push, out_write, out_last, rsp_req, rsp_push, rsp_error;
  logic [31:0] out_addr, rsp_data;
  logic [63:0] out_wdata;
  logic [7:0]  out_be, out_srcid, out_plen;
  logic [3:0]  out_trdid, out_pktid;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  cmd_pack_router dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_addr(in_addr), .in_write(in_write), .in_wdata(in_wdata), .in_be(in_be),
    .in_last(in_last), .in_srcid(in_srcid), .in_trdid(in_trdid), .in_pktid(in_pktid),
    .in_plen(in_plen), .out_push(out_push), .out_space(out_space), .out_addr(out_addr),
    .out_write(out_write), .out_wdata(out_wdata), .out_be(out_be), .out_last(out_last),
    .out_srcid(out_srcid), .out_trdid(out_trdid), .out_pktid(out_pktid), .out_plen(out_plen),
    .rsp_req(rsp_req), .rsp_grant(rsp_grant), .rsp_push(rsp_push), .rsp_data(rsp_data),
    .rsp_error(rsp_error));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send(input logic [31:0] a, input logic w, input logic [31:0] d,
                      input logic [3:0] be, input logic last);
    @(negedge clk);
    in_valid = 1; in_addr = a; in_write = w; in_wdata = d; in_be = be; in_last = last;
    @(negedge clk);
    in_valid = 0; in_wdata = 32'hDEAD_BEEF; in_addr = 32'h0;
  endtask

  task automatic t_reset;
    chk("R1 in_ready", in_ready, 1);
    chk("R1 out_push", out_push, 0);
    chk("R1 rsp_req", rsp_req, 0);
    chk("R1 rsp_push", rsp_push, 0);
  endtask

  task automatic t_single_hi;
    out_space = 1;
    send(32'h1000_0004, 1, 32'hA5A5_0001, 4'h3, 1);
    chk("R4 push", out_push, 1);
    chk("R2 busy", in_ready, 0);
    chk("R3 hi data", out_wdata, 64'hA5A5_0001_0000_0000);
    chk("R3 hi be", out_be, 8'h30);
    chk("R4 last", out_last, 1);
    @(negedge clk);
    chk("R7 single push", out_push, 0);
    chk("R2 idle ready", in_ready, 1);
  endtask

  task automatic t_single_lo;
    send(32'h2000_0008, 0, 32'h1234_5678, 4'hF, 1);
    chk("R3 lo data", out_wdata, 64'h0000_0000_1234_5678);
    chk("R3 lo be", out_be, 8'h0F);
    chk("R4 read cmd", out_write, 0);
    chk("R4 addr", out_addr, 32'h2000_0008);
    @(negedge clk);
  endtask

  task automatic t_burst;
    send(32'h1000_0010, 1, 32'h1111_2222, 4'hF, 0);
    chk("R6 wait no push", out_push, 0);
    chk("R6 ready for second", in_ready, 1);
    send(32'h1000_0014, 1, 32'h3333_4444, 4'hC, 1);
    chk("R6 merged push", out_push, 1);
    chk("R6 merged data", out_wdata, 64'h3333_4444_1111_2222);
    chk("R6 merged be", out_be, 8'hCF);
    chk("R6 last copied", out_last, 1);
    @(negedge clk);
  endtask

  task automatic t_hi_nonlast;
    send(32'h1000_0024, 1, 32'h0BAD_F00D, 4'hF, 0);
    chk("R5 push", out_push, 1);
    chk("R5 last", out_last, 0);
    chk("R5 be", out_be, 8'hF0);
    @(negedge clk);
  endtask

  task automatic t_stall;
    out_space = 0;
    in_srcid = 8'h55; in_trdid = 4'h6; in_pktid = 4'h9; in_plen = 8'h04;
    send(32'h2000_0100, 1, 32'hCAFE_0000, 4'hF, 1);
    in_srcid = 8'hAA; in_trdid = 0; in_pktid = 0; in_plen = 0;
    for (int i = 0; i < 3; i++) begin
      chk("R7 held push", out_push, 1);
      chk("R7 srcid captured", out_srcid, 8'h55);
      chk("R7 data captured", out_wdata, 64'h0000_0000_CAFE_0000);
      @(negedge clk);
    end
    chk("R7 trdid", out_trdid, 4'h6);
    chk("R7 pktid", out_pktid, 4'h9);
    chk("R7 plen", out_plen, 8'h04);
    chk("R2 busy while held", in_ready, 0);
    out_space = 1;
    @(negedge clk);
    chk("R7 released", out_push, 0);
  endtask

  task automatic t_local;
    rsp_grant = 1;
    send(32'h0000_1008, 1, 32'hFEED_0002, 4'hF, 1);
    chk("R8 rsp push", rsp_push, 1);
    chk("R8 no out push", out_push, 0);
    chk("R8 write err", rsp_error, 0);
    @(negedge clk);
    send(32'h0000_1008, 0, 32'h0, 4'hF, 1);
    chk("R8 read data", rsp_data, 32'hFEED_0002);
    chk("R8 read err", rsp_error, 0);
    @(negedge clk);
  endtask

  task automatic t_local_err;
    send(32'h0000_1024, 0, 32'h0, 4'hF, 1);
    chk("R9 bad index err", rsp_error, 1);
    chk("R9 bad index data", rsp_data, 0);
    @(negedge clk);
    send(32'h0000_1004, 1, 32'h7777_7777, 4'h7, 1);
    chk("R9 partial be err", rsp_error, 1);
    @(negedge clk);
    send(32'h0000_1004, 0, 32'h0, 4'hF, 1);
    chk("R9 register untouched", rsp_data, 32'h0);
    chk("R9 clean read", rsp_error, 0);
    @(negedge clk);
  endtask

  task automatic t_miss;
    rsp_grant = 0;
    send(32'h3000_0000, 1, 32'h1, 4'hF, 0);
    chk("R10 no rsp on non-last", rsp_req, 0);
    chk("R10 consumed", in_ready, 1);
    send(32'h3000_0004, 1, 32'h2, 4'hF, 1);
    chk("R10 rsp req", rsp_req, 1);
    chk("R10 err", rsp_error, 1);
    chk("R10 data", rsp_data, 0);
    chk("R10 no out push", out_push, 0);
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      chk("R11 waiting", rsp_req, 1);
      chk("R11 no push w/o grant", rsp_push, 0);
    end
    rsp_grant = 1;
    #1;
    chk("R11 push on grant", rsp_push, 1);
    @(negedge clk);
    chk("R11 back idle", rsp_req, 0);
    chk("R11 ready", in_ready, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_single_hi;
    t_single_lo;
    t_burst;
    t_hi_nonlast;
    t_stall;
    t_local;
    t_local_err;
    t_miss;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule